// File: doc/BRIEF.md
# Dual-Role DMA Request / Interrupt Pin Controller

This block looks after a set of external input pins (two by default). Each pin belongs to one DMA channel and has two possible roles. When its channel is enabled and set to take its transfer requests from outside, the pin is treated as a DMA request. The block synchronizes the pin and passes it on as a level. In every other channel setting, the same pin becomes a spare maskable interrupt input. It is detected on its rising edge, and it has no type code or control bits of its own. It borrows the channel's interrupt type code and mask.

Each channel has one shared interrupt request line. That line is raised when either the pin interrupt or the DMA channel's internal interrupt is pending and the channel is not masked. One acknowledge clears both sources. The block does not contain the DMA engine, the priority resolver or the vector fetch. It sits between the pins and those units.

Top module: `dpc_pin_ctrl`

## Requirements
- R1: After reset, every `dma_req_o` and `irq_req_o` bit is 0. `irq_type_o` always holds the type code of channel n in bits [8n+7:8n]: 0x0A for channel 0 and 0x0B for channel 1.
- R2: A channel is in request mode when its enable and its external-sync select are both 1. In request mode, `dma_req_o` follows the pin level through a two-flop synchronizer. A pin change driven before clock edge k shows at the output after edge k+1. The request is not held: releasing the pin drops it on the same latency.
- R3: Outside request mode, `dma_req_o` is 0. In request mode, pin activity sets no interrupt.
- R4: Outside request mode, a rising edge of the synchronized pin sets the pin-pending flag. The request appears after the third clock edge that follows the pin rise. Holding the pin high yields only one event.
- R5: If the pin returns low before acknowledge, the pin-pending flag is withdrawn. This happens once the low level has passed the synchronizer.
- R6: While the mask bit is 1, `irq_req_o` is 0, but the pending state is kept. Clearing the mask raises the request again on the next cycle.
- R7: An acknowledge clears both pending sources of the channel. A pin still held high after acknowledge raises nothing until it goes low and high again. A new event in the same cycle as the acknowledge wins.
- R8: A one-cycle pulse on `dma_int_i` sets the internal pending flag. That flag drives the same shared `irq_req_o` line as the pin interrupt.
- R9: Leaving request mode while the pin is held high creates no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_CH | Raw asynchronous dual-role pins |
| ch_enable_i | input | NUM_CH | DMA channel enabled |
| ch_extsync_i | input | NUM_CH | Channel takes requests from its pin |
| irq_mask_i | input | NUM_CH | Shared interrupt mask, 1 = masked |
| irq_ack_i | input | NUM_CH | Interrupt acknowledge pulse per channel |
| dma_int_i | input | NUM_CH | Internal DMA channel interrupt pulse |
| dma_req_o | output | NUM_CH | Synchronized DMA request level |
| irq_req_o | output | NUM_CH | Shared interrupt request per channel |
| irq_type_o | output | NUM_CH*TYPE_W | Type code per channel |

## Verification
Some properties are checked by assertions on every cycle. A pending flag may only rise after a synchronized low-to-high step. A low pin always empties the pin-pending flag on the following cycle. Request mode always leaves that flag clear. An acknowledge with no new event clears both sources.

Other behaviour needs the bench scenarios to show it. These include the exact latency from a pin edge to each output, that a mask hides a request without losing it, and that a pin held high past an acknowledge or across a mode switch raises nothing. They also include the interplay of both sources on one line under random traffic.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

   localparam int unsigned DPC_TYPE_W_DEF = 8;

   typedef enum logic [0:0] {
      ROLE_IRQ = 1'b0,
      ROLE_DMA = 1'b1
   } pin_role_e;

   function automatic pin_role_e role_of(input logic enable, input logic extsync);
      return (enable && extsync) ? ROLE_DMA : ROLE_IRQ;
   endfunction

endpackage

// File: rtl/dpc_sync.sv
module dpc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   initial begin
      assert (STAGES >= 2) else $error("dpc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dpc_pin_pend.sv
module dpc_pin_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s_i,
   input  logic irq_role_i,
   input  logic ack_i,
   output logic pend_o
);
   logic prev_q;
   logic pend_q;
   logic rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_s_i;
   end

   assign rise = pin_s_i & ~prev_q & irq_role_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (rise)   pend_q <= 1'b1;
      else if (ack_i)  pend_q <= 1'b0;
      else             pend_q <= pend_q & pin_s_i & irq_role_i;
   end

   assign pend_o = pend_q;

   a_r4_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(pin_s_i) && !$past(prev_q));
   a_r5_release_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_s_i |=> !pend_q);
   a_r3_none_in_dma: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_role_i |=> !pend_q);
   a_r7_ack_clears_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !(pin_s_i && !prev_q)) |=> !pend_q);
endmodule

// File: rtl/dpc_chan.sv
module dpc_chan
   import dpc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TYPE_W      = 8,
   parameter logic [TYPE_W-1:0] TYPE_CODE = 8'h0A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_i,
   input  logic              enable_i,
   input  logic              extsync_i,
   input  logic              mask_i,
   input  logic              ack_i,
   input  logic              dma_int_i,
   output logic              dma_req_o,
   output logic              irq_req_o,
   output logic [TYPE_W-1:0] type_o
);
   logic      pin_s;
   logic      pin_pend;
   logic      int_pend_q;
   pin_role_e role;

   dpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pin_i),
      .q_o  (pin_s)
   );

   assign role = role_of(enable_i, extsync_i);

   dpc_pin_pend u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_s_i   (pin_s),
      .irq_role_i(role == ROLE_IRQ),
      .ack_i     (ack_i),
      .pend_o    (pin_pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         int_pend_q <= 1'b0;
      else if (dma_int_i) int_pend_q <= 1'b1;
      else if (ack_i)     int_pend_q <= 1'b0;
   end

   assign dma_req_o = (role == ROLE_DMA) & pin_s;
   assign irq_req_o = (pin_pend | int_pend_q) & ~mask_i;
   assign type_o    = TYPE_CODE;

   a_r8_int_sets: assert property (@(posedge clk) disable iff (!rst_n)
      dma_int_i |=> int_pend_q);
   a_r7_ack_clears_int: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !dma_int_i) |=> !int_pend_q);
   a_r2_dma_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (role == ROLE_DMA && $past(role == ROLE_DMA) && $rose(dma_req_o)) |-> $rose(pin_s));
endmodule

// File: rtl/dpc_pin_ctrl.sv
module dpc_pin_ctrl #(
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TYPE_W      = 8,
   parameter logic [7:0]  BASE_TYPE   = 8'h0A
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CH-1:0]          pin_i,
   input  logic [NUM_CH-1:0]          ch_enable_i,
   input  logic [NUM_CH-1:0]          ch_extsync_i,
   input  logic [NUM_CH-1:0]          irq_mask_i,
   input  logic [NUM_CH-1:0]          irq_ack_i,
   input  logic [NUM_CH-1:0]          dma_int_i,
   output logic [NUM_CH-1:0]          dma_req_o,
   output logic [NUM_CH-1:0]          irq_req_o,
   output logic [NUM_CH*TYPE_W-1:0]   irq_type_o
);
   localparam int unsigned TYPE_SPAN = 1 << TYPE_W;

   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= 8) else $error("dpc_pin_ctrl: NUM_CH out of range");
      assert (TYPE_W >= 8) else $error("dpc_pin_ctrl: TYPE_W too small");
      assert (int'(BASE_TYPE) + NUM_CH <= TYPE_SPAN) else $error("dpc_pin_ctrl: type codes overflow");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [TYPE_W-1:0] CODE = TYPE_W'(BASE_TYPE) + TYPE_W'(c);
      dpc_chan #(
         .SYNC_STAGES(SYNC_STAGES),
         .TYPE_W     (TYPE_W),
         .TYPE_CODE  (CODE)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_i     (pin_i[c]),
         .enable_i  (ch_enable_i[c]),
         .extsync_i (ch_extsync_i[c]),
         .mask_i    (irq_mask_i[c]),
         .ack_i     (irq_ack_i[c]),
         .dma_int_i (dma_int_i[c]),
         .dma_req_o (dma_req_o[c]),
         .irq_req_o (irq_req_o[c]),
         .type_o    (irq_type_o[c*TYPE_W +: TYPE_W])
      );
   end

   a_r6_mask_hides: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req_o & irq_mask_i) == '0);
   a_r3_dma_only_in_role: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req_o & ~(ch_enable_i & ch_extsync_i)) == '0);
endmodule

// File: tb/dpc_pin_ctrl_bench.sv
module dpc_pin_ctrl_bench;
   localparam int NCH = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] pin = '0, en = '0, ext = '0, mask = '0, ack = '0, dint = '0;
   logic [NCH-1:0] dma_req, irq_req;
   logic [NCH*8-1:0] itype;

   int n_checks = 0;
   int n_errors = 0;
   bit cmp_on = 1'b0;

   always #4 clk = ~clk;

   dpc_pin_ctrl u_dpc_pin_ctrl (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .ch_enable_i(en), .ch_extsync_i(ext),
      .irq_mask_i(mask), .irq_ack_i(ack), .dma_int_i(dint),
      .dma_req_o(dma_req), .irq_req_o(irq_req), .irq_type_o(itype)
   );

   // Reference model built from the requirements.
   logic [NCH-1:0] m_s1, m_s2, m_prev, m_pp, m_dp;

   function automatic logic [NCH-1:0] dma_role(input logic [NCH-1:0] e, input logic [NCH-1:0] x);
      return e & x;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pp <= '0; m_dp <= '0;
      end else begin
         for (int c = 0; c < NCH; c++) begin
            logic irqm, rise;
            irqm = !dma_role(en, ext)[c];
            rise = m_s2[c] && !m_prev[c] && irqm;
            if (rise)        m_pp[c] <= 1'b1;
            else if (ack[c]) m_pp[c] <= 1'b0;
            else             m_pp[c] <= m_pp[c] && m_s2[c] && irqm;
            if (dint[c])     m_dp[c] <= 1'b1;
            else if (ack[c]) m_dp[c] <= 1'b0;
         end
         m_s1 <= pin; m_s2 <= m_s1; m_prev <= m_s2;
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (cmp_on) begin
            chk("R2 model dma_req", 16'(dma_req), 16'(dma_role(en, ext) & m_s2));
            chk("R6 model irq_req", 16'(irq_req), 16'((m_pp | m_dp) & ~mask));
         end
      end
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      tick(3);
      chk("R1 reset dma_req", 16'(dma_req), 16'h0);
      chk("R1 reset irq_req", 16'(irq_req), 16'h0);
      chk("R1 type codes", itype, 16'h0B0A);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      tick(2);

      // R2: request mode follows the pin with two-edge latency, not held.
      en = 2'b01; ext = 2'b01; pin[0] = 1'b1;
      tick(1); chk("R2 latency early", 16'(dma_req[0]), 16'h0);
      tick(1); chk("R2 dma_req up", 16'(dma_req[0]), 16'h1);
      chk("R3 no irq in dma mode", 16'(irq_req[0]), 16'h0);
      pin[0] = 1'b0;
      tick(2); chk("R2 dma_req withdrawn", 16'(dma_req[0]), 16'h0);

      // R4: interrupt role, edge after three edges.
      ext = 2'b00; tick(2);
      pin[0] = 1'b1;
      tick(2); chk("R4 not yet", 16'(irq_req[0]), 16'h0);
      tick(1); chk("R4 irq up", 16'(irq_req[0]), 16'h1);
      chk("R3 dma_req low in irq role", 16'(dma_req[0]), 16'h0);

      // R6: mask hides, keeps pending.
      mask[0] = 1'b1; tick(1); chk("R6 masked", 16'(irq_req[0]), 16'h0);
      mask[0] = 1'b0; tick(1); chk("R6 unmasked", 16'(irq_req[0]), 16'h1);

      // R7: ack clears, held pin does not re-request.
      ack[0] = 1'b1; tick(1); ack[0] = 1'b0;
      chk("R7 ack clears", 16'(irq_req[0]), 16'h0);
      tick(5); chk("R7 held high no retrigger", 16'(irq_req[0]), 16'h0);

      // R5: release before ack withdraws.
      pin[0] = 1'b0; tick(3); pin[0] = 1'b1; tick(3);
      chk("R4 second edge", 16'(irq_req[0]), 16'h1);
      pin[0] = 1'b0;
      tick(2); chk("R5 still pending", 16'(irq_req[0]), 16'h1);
      tick(1); chk("R5 withdrawn", 16'(irq_req[0]), 16'h0);

      // R8: internal DMA interrupt on shared line, channel 1.
      dint[1] = 1'b1; tick(1); dint[1] = 1'b0;
      chk("R8 internal sets", 16'(irq_req[1]), 16'h1);
      tick(2); chk("R8 held pending", 16'(irq_req[1]), 16'h1);
      ack[1] = 1'b1; dint[1] = 1'b1; tick(1); ack[1] = 1'b0; dint[1] = 1'b0;
      chk("R7 new event wins over ack", 16'(irq_req[1]), 16'h1);
      ack[1] = 1'b1; tick(1); ack[1] = 1'b0;
      chk("R7 ack clears internal", 16'(irq_req[1]), 16'h0);

      // R9: leaving request mode with pin high.
      en[1] = 1'b1; ext[1] = 1'b1; pin[1] = 1'b1; tick(4);
      chk("R2 ch1 dma_req", 16'(dma_req[1]), 16'h1);
      ext[1] = 1'b0; tick(4);
      chk("R9 no irq on role switch", 16'(irq_req[1]), 16'h0);
      chk("R3 dma_req drops on switch", 16'(dma_req[1]), 16'h0);

      // Constrained random traffic against the model.
      for (int k = 0; k < 3000; k++) begin
         for (int c = 0; c < NCH; c++) begin
            if ($urandom_range(7) == 0) pin[c] = ~pin[c];
            if ($urandom_range(40) == 0) ext[c] = ~ext[c];
            if ($urandom_range(60) == 0) en[c] = ~en[c];
            mask[c] = ($urandom_range(9) == 0);
            ack[c]  = ($urandom_range(11) == 0);
            dint[c] = ($urandom_range(29) == 0);
         end
         tick(1);
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule